// File: doc/BRIEF.md
# Flash Busy-Status Read Responder

This block stands in front of a self-timed flash array and decides what a read returns while the array is occupied with an internal write or erase. A one-cycle start pulse launches an operation of a chosen kind (byte program, sector erase or chip erase) together with the byte being written. From then on the block holds a busy flag for a number of clock cycles fixed per operation kind by parameters. The defaults correspond to 35 µs, 10 ms and 3 s at a 50 MHz clock.

Reads travel through a valid/ready pair on the request side and a valid/ready pair on the response side. While the operation runs, each accepted read is answered with a status byte instead of array contents. Bit 7 of that byte is a polarity flag: for a program it is the inverse of bit 7 of the byte being written, and for an erase it is 0. Bit 6 changes on every accepted read, and bits 5..0 are 0. Once the busy period ends, reads return the array byte presented on `arr_data` unchanged. A start that arrives while an operation is running is discarded and leaves a sticky flag that only reset clears.

Back-pressure rules: a request is accepted on a clock edge where `rd_req_valid` and `rd_req_ready` are both high. `rd_req_ready` is high whenever no response is waiting or the waiting one is being taken in the same cycle. A response appears on `rsp_valid`/`rsp_data` in the cycle after its request is accepted. It stays unchanged until a clock edge where `rsp_ready` is high.

Top module: `flash_busy_status`

## Requirements
- R1: Under reset `busy`, `rsp_valid` and `start_dropped` are 0 and `rd_req_ready` is 1.
- R2: A start seen while idle raises `busy` on that clock edge, and `busy` stays high for exactly PROG_CYCLES, SECT_CYCLES or CHIP_CYCLES cycles, according to the operation kind.
- R3: While a byte program is busy, bit 7 of each read response is the inverse of bit 7 of `wr_data` captured with the start.
- R4: While a sector or chip erase is busy, bit 7 of each read response is 0.
- R5: During busy, bit 6 of the first read response after each start is 0 and flips on each later accepted read; bits 5..0 are 0.
- R6: A read accepted while not busy returns the `arr_data` value present at acceptance.
- R7: A start seen while busy neither restarts the timer nor changes the status byte, and it sets `start_dropped`, which stays set until reset.
- R8: A response appears the cycle after acceptance. It holds value while `rsp_ready` is low, and `rd_req_ready` equals NOT `rsp_valid` OR `rsp_ready`.
- R9: `op` encoding: 0 byte program, 1 sector erase, 2 chip erase, 3 treated as chip erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle operation launch |
| op | input | 2 | Operation kind (see R9) |
| wr_data | input | 8 | Byte being written, captured with start |
| rd_req_valid | input | 1 | Read request valid |
| rd_req_ready | output | 1 | Read request can be accepted |
| arr_data | input | 8 | True array byte for the current read |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 8 | Read response byte |
| busy | output | 1 | Internal operation in progress |
| start_dropped | output | 1 | Sticky: a start arrived while busy |

## Verification
The hardest case to reach is the meeting of a stalled response with a running operation. The status byte must be frozen at acceptance while bit 6 keeps its place in the flip sequence, and a refused request must not advance that sequence. The stimulus therefore lowers `rsp_ready` partway through a busy period and keeps a request pending for several cycles. It also fires a second start inside the same period and reads again at the exact end of busy. Every operation kind is run, with both values of the written bit 7.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [1:0] {
    OP_PROG     = 2'd0,
    OP_SECT     = 2'd1,
    OP_CHIP     = 2'd2,
    OP_CHIP_ALT = 2'd3
  } op_e;

  function automatic logic op_is_erase(input op_e o);
    return (o != OP_PROG);
  endfunction
endpackage

// File: rtl/fbs_busy_timer.sv
module fbs_busy_timer
  import flash_stat_pkg::*;
#(
  parameter int PROG_CYCLES = 1750,
  parameter int SECT_CYCLES = 500000,
  parameter int CHIP_CYCLES = 150000000,
  parameter int CW          = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  op_e  op,
  output logic busy
);
  localparam logic [CW-1:0] PROG_LD = CW'(PROG_CYCLES - 1);
  localparam logic [CW-1:0] SECT_LD = CW'(SECT_CYCLES - 1);
  localparam logic [CW-1:0] CHIP_LD = CW'(CHIP_CYCLES - 1);

  logic [CW-1:0] remain;
  logic [CW-1:0] load_val;

  always_comb begin
    unique case (op)
      OP_PROG: load_val = PROG_LD;
      OP_SECT: load_val = SECT_LD;
      default: load_val = CHIP_LD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (load) begin
      busy   <= 1'b1;
      remain <= load_val;
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/fbs_status_gen.sv
module fbs_status_gen
  import flash_stat_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  op_e           op,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_fire,
  input  logic          busy,
  output logic [DW-1:0] stat_byte
);
  localparam int POLL_BIT = DW - 1;
  localparam int TOG_BIT  = DW - 2;

  logic poll_q;
  logic tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= 1'b0;
      tog_q  <= 1'b0;
    end else if (load) begin
      poll_q <= op_is_erase(op) ? 1'b0 : ~wr_data[POLL_BIT];
      tog_q  <= 1'b0;
    end else if (rd_fire && busy) begin
      tog_q  <= ~tog_q;
    end
  end

  always_comb begin
    stat_byte           = '0;
    stat_byte[POLL_BIT] = poll_q;
    stat_byte[TOG_BIT]  = tog_q;
  end
endmodule

// File: rtl/fbs_rsp_stage.sv
module fbs_rsp_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_valid && in_ready) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_busy_status.sv
module flash_busy_status
  import flash_stat_pkg::*;
#(
  parameter int PROG_CYCLES = 1750,
  parameter int SECT_CYCLES = 500000,
  parameter int CHIP_CYCLES = 150000000,
  parameter int DW          = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_req_valid,
  output logic          rd_req_ready,
  input  logic [DW-1:0] arr_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          busy,
  output logic          start_dropped
);
  localparam int MAX_A  = (PROG_CYCLES > SECT_CYCLES) ? PROG_CYCLES : SECT_CYCLES;
  localparam int MAX_CY = (MAX_A > CHIP_CYCLES) ? MAX_A : CHIP_CYCLES;
  localparam int CW     = $clog2(MAX_CY + 1);

  op_e           op_q;
  logic          launch;
  logic          rd_fire;
  logic [DW-1:0] stat_byte;
  logic [DW-1:0] sel_data;

  assign op_q    = op_e'(op);
  assign launch  = start && !busy;
  assign rd_fire = rd_req_valid && rd_req_ready;
  assign sel_data = busy ? stat_byte : arr_data;

  fbs_busy_timer #(
    .PROG_CYCLES(PROG_CYCLES),
    .SECT_CYCLES(SECT_CYCLES),
    .CHIP_CYCLES(CHIP_CYCLES),
    .CW(CW)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .load(launch), .op(op_q), .busy(busy)
  );

  fbs_status_gen #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n), .load(launch), .op(op_q), .wr_data(wr_data),
    .rd_fire(rd_fire), .busy(busy), .stat_byte(stat_byte)
  );

  fbs_rsp_stage #(.DW(DW)) u_rsp (
    .clk(clk), .rst_n(rst_n), .in_valid(rd_req_valid), .in_data(sel_data),
    .in_ready(rd_req_ready), .out_valid(rsp_valid), .out_ready(rsp_ready),
    .out_data(rsp_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               start_dropped <= 1'b0;
    else if (start && busy)   start_dropped <= 1'b1;
  end
endmodule

// File: rtl/flash_busy_status_chk.sv
module flash_busy_status_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic          rsp_valid,
  input logic          rsp_ready,
  input logic [DW-1:0] rsp_data,
  input logic          busy,
  input logic          start_dropped
);
  // R2
  start_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start |=> !busy);
  // R7
  drop_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && busy |=> start_dropped);
  // R7
  drop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_dropped |=> start_dropped);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R8
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready |=> rsp_valid);
  // R5
  low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && rd_req_ready && busy |=> rsp_data[DW-3:0] == '0);
endmodule

bind flash_busy_status flash_busy_status_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data), .busy(busy), .start_dropped(start_dropped)
);

// File: tb/sim_flash_busy_status.sv
module sim_flash_busy_status;
  localparam int CLK_PERIOD = 10;
  localparam int P_PROG = 12;
  localparam int P_SECT = 30;
  localparam int P_CHIP = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_req_valid = 1'b0;
  logic       rd_req_ready;
  logic [7:0] arr_data = 8'h00;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       busy;
  logic       start_dropped;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  flash_busy_status #(
    .PROG_CYCLES(P_PROG), .SECT_CYCLES(P_SECT), .CHIP_CYCLES(P_CHIP), .DW(8)
  ) u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // Scoreboard model, built from the requirements
  logic       m_busy = 1'b0, m_pb = 1'b0, m_tog = 1'b0, m_rv = 1'b0, m_drop = 1'b0, m_er = 1'b0;
  int         m_cnt = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    logic acc, old_busy;
    if (!rst_n) begin
      m_busy = 0; m_pb = 0; m_tog = 0; m_rv = 0; m_drop = 0; m_cnt = 0;
    end else begin
      acc = rd_req_valid && (!m_rv || rsp_ready);
      if (acc) begin
        if (m_busy) begin
          exp_q.push_back({m_pb, m_tog, 6'b0});
          tag_q.push_back(m_er ? "R4 R5" : "R3 R5");
          m_tog = ~m_tog;
        end else begin
          exp_q.push_back(arr_data);
          tag_q.push_back("R6");
        end
      end
      m_rv = acc ? 1'b1 : (rsp_ready ? 1'b0 : m_rv);
      old_busy = m_busy;
      if (m_busy) begin
        if (m_cnt == 1) m_busy = 0;
        else m_cnt--;
      end
      if (start) begin
        if (!old_busy) begin
          m_busy = 1; m_tog = 0;
          m_er   = (op != 2'd0);   // R9: 1,2,3 are erases
          m_pb   = m_er ? 1'b0 : ~wr_data[7];
          m_cnt  = (op == 2'd0) ? P_PROG : (op == 2'd1) ? P_SECT : P_CHIP;
        end else begin
          m_drop = 1;
        end
      end
    end
  end

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(busy == m_busy, "R2 R9 busy", busy, m_busy);
      check(start_dropped == m_drop, "R7 dropped flag", start_dropped, m_drop);
      check(rsp_valid == m_rv, "R8 rsp_valid", rsp_valid, m_rv);
      check(rd_req_ready == (!m_rv || rsp_ready), "R8 rd_req_ready", rd_req_ready, !m_rv || rsp_ready);
      if (rsp_valid && rsp_ready && exp_q.size() > 0) begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rsp_data == e, {t, " rsp_data"}, rsp_data, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic go(input logic [1:0] o, input logic [7:0] d);
    start = 1; op = o; wr_data = d;
    tick(1);
    start = 0;
  endtask

  task automatic rd(input logic [7:0] a);
    rd_req_valid = 1; arr_data = a;
    tick(1);
    rd_req_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) tick(1);
    tick(1);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog R2 run did not end");
      finish_run();
    end
  end

  initial begin
    tick(3);
    @(negedge clk);
    // R1 reset values
    check(busy == 0, "R1 busy", busy, 0);
    check(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);
    check(start_dropped == 0, "R1 dropped", start_dropped, 0);
    check(rd_req_ready == 1, "R1 rd_req_ready", rd_req_ready, 1);
    @(posedge clk); #1;
    rst_n = 1;
    tick(2);
    rd(8'h5A);                 // R6 idle read
    tick(1);
    go(2'd0, 8'hC3);           // R3 program, bit7=1 -> poll 0
    rd(8'h11); rd(8'h22); rd(8'h33); rd(8'h44);
    rsp_ready = 0;             // R8 back-pressure during busy
    rd(8'h55);
    rd_req_valid = 1; arr_data = 8'h66;
    tick(3);
    rsp_ready = 1;
    tick(1);
    rd_req_valid = 0;
    go(2'd1, 8'h00);           // R7 dropped while busy
    rd(8'h77);
    wait_idle();
    rd(8'h9E);                 // R6 after completion
    tick(1);
    go(2'd0, 8'h35);           // R3 bit7=0 -> poll 1
    rd(8'h01); rd(8'h02); rd(8'h03);
    wait_idle();
    go(2'd1, 8'h80);           // R4 sector erase
    rd(8'h04); rsp_ready = 0; rd(8'h05); tick(2); rsp_ready = 1; rd(8'h06);
    wait_idle();
    rd(8'hA7);
    go(2'd2, 8'h80);           // R4 chip erase
    rd(8'h08); rd(8'h09);
    wait_idle();
    go(2'd3, 8'h12);           // R9 code 3 as chip erase
    rd(8'h0A); rd(8'h0B); rd(8'h0C);
    wait_idle();
    rd(8'hE1);
    tick(4);
    check(exp_q.size() == 0, "R8 all responses delivered", exp_q.size(), 0);
    done = 1;
    finish_run();
  end
endmodule